// File: doc/BRIEF.md
# Multi-expiry watchdog with keyed disable

This block joins a programmable down-counting timer and a watchdog supervisor in one memory-mapped peripheral. Software loads a period into the timer. The timer counts down to zero, raises a pending flag, and either reloads itself (periodic mode) or stops (one-shot mode). The supervisor counts timer expiries that software has not serviced. A reset goes out only after a run of such expiries, so one late service does not reset the system.

Software services the watchdog in one of two ways: it clears the timer's pending flag, or it issues a fresh start command. Both set the expiry run back to zero. Stopping the supervisor is guarded. A key value has to land in a dedicated register immediately before the stop command, otherwise the command is dropped. A write to the register port is a single cycle with `wr_en` high. `wdt_sel` picks the timer space (0) or the watchdog space (1), and `addr` is the byte offset inside that space. Reads are combinational on `rdata`.

Top module: `wdt_expiry_guard`

## Requirements
- R1: A write to timer offset 0x0 loads enable (bit 31), periodic mode (bit 30) and period P (bits 29:0). With enable set, the pending flag rises exactly P+1 cycles after the write. In periodic mode this repeats every P+1 cycles.
- R2: In one-shot mode (bit 30 clear) the timer expires once. It then clears its own enable bit, and offset 0x0 reads back with bit 31 low.
- R3: Writing zero to timer offset 0x0 stops the timer. No further expiries occur, and the register reads zero.
- R4: Writing 1 to bit 30 of timer offset 0x4 clears the pending flag. Bit 30 of that offset reads the pending flag.
- R5: `irq` is high exactly when the pending flag is set and interrupt enable (watchdog offset 0x0 bit 12) is set.
- R6: While the supervisor is running, the 4th consecutive unserviced expiry gives a one-cycle `sys_rst` pulse if bit 14 of the configuration is set. It gives a one-cycle `aux_rst` pulse if bit 15 is set. The pulses appear in the same cycle the pending flag rises, and the run then starts over.
- R7: Clearing the pending flag, or writing bit 0 of watchdog offset 0x8 (start), sets the expiry run to zero. Writing start also sets the supervisor running.
- R8: Writing bit 1 of watchdog offset 0x8 stops the supervisor only if the previous watchdog-space write was 0x0000C45A to offset 0xC. The stop is ignored after a wrong key, after an intervening watchdog write, or with no key at all.
- R9: The supervisor counts expiries only when the source field (configuration bits 3:0) is 0.
- R10: All registers read zero after reset. The configuration reads back as written in bits 15, 14, 12 and 3:0. Bit 0 of watchdog offset 0x8 reads the running state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wdt_sel | input | 1 | 0 selects timer space, 1 selects watchdog space |
| addr | input | 4 | Byte offset within the selected space |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the addressed register |
| irq | output | 1 | Pending timer interrupt, gated by interrupt enable |
| sys_rst | output | 1 | One-cycle system reset pulse |
| aux_rst | output | 1 | One-cycle secondary reset request pulse |

## Verification
The bench builds the block with its default parameters: a 30-bit period field, a run length of four expiries, and the 0xC45A key. It drives only small period values, and the whole 4×(P+1) path to reset can then be swept for every period from 0 to 5, with cycle positions predicted arithmetically. Short periods also keep the one-shot, servicing, restart, gating, source-select and key-ordering scenarios within a few dozen cycles each.

// File: rtl/wdt_expiry_guard.sv
module wdt_expiry_guard #(
  parameter int          PERIOD_W   = 30,
  parameter int          EXPIRIES   = 4,
  parameter int          SRC_W      = 4,
  parameter logic [31:0] UNLOCK_KEY = 32'h0000_C45A
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wdt_sel,
  input  logic [3:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq,
  output logic        sys_rst,
  output logic        aux_rst
);
  localparam int CW = $clog2(EXPIRIES + 1);
  localparam logic [CW-1:0] LAST = CW'(EXPIRIES - 1);

  logic                tmr_en, tmr_per, pend;
  logic [PERIOD_W-1:0] period, count;
  logic                int_en, rst_en, aux_en, running, unlocked;
  logic [SRC_W-1:0]    src;
  logic [CW-1:0]       exp_cnt;

  logic tv_wr, tc_wr, cfg_wr, cmd_wr, key_wr, wdt_wr;
  logic pend_clr, fire, tick, last, do_stop, do_start, service;
  logic unused_bits;

  assign tv_wr  = wr_en & ~wdt_sel & (addr == 4'h0);
  assign tc_wr  = wr_en & ~wdt_sel & (addr == 4'h4);
  assign wdt_wr = wr_en & wdt_sel;
  assign cfg_wr = wdt_wr & (addr == 4'h0);
  assign cmd_wr = wdt_wr & (addr == 4'h8);
  assign key_wr = wdt_wr & (addr == 4'hC);

  assign pend_clr = tc_wr & wdata[30];
  assign fire     = tmr_en & (count == '0);
  assign tick     = fire & running & (src == '0);
  assign last     = tick & (exp_cnt == LAST);
  assign do_stop  = cmd_wr & wdata[1] & unlocked;
  assign do_start = cmd_wr & wdata[0] & ~do_stop;
  assign service  = pend_clr | do_start;
  assign unused_bits = ^wdata;

  // timer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr_en <= 1'b0;
      tmr_per <= 1'b0;
      period <= '0;
      count <= '0;
    end else if (tv_wr) begin
      tmr_en <= wdata[31];
      tmr_per <= wdata[30];
      period <= wdata[PERIOD_W-1:0];
      count <= wdata[PERIOD_W-1:0];
    end else if (fire) begin
      count <= period;
      if (!tmr_per) tmr_en <= 1'b0;
    end else if (tmr_en) begin
      count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        pend <= 1'b0;
    else if (fire)     pend <= 1'b1;
    else if (pend_clr) pend <= 1'b0;
  end

  // supervisor
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_en <= 1'b0;
      rst_en <= 1'b0;
      aux_en <= 1'b0;
      src <= '0;
    end else if (cfg_wr) begin
      int_en <= wdata[12];
      rst_en <= wdata[14];
      aux_en <= wdata[15];
      src <= wdata[SRC_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      unlocked <= 1'b0;
    else if (wdt_wr) unlocked <= key_wr & (wdata == UNLOCK_KEY);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        running <= 1'b0;
    else if (do_stop)  running <= 1'b0;
    else if (do_start) running <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                             exp_cnt <= '0;
    else if (do_stop || service || last)    exp_cnt <= '0;
    else if (tick)                          exp_cnt <= exp_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sys_rst <= 1'b0;
      aux_rst <= 1'b0;
    end else begin
      sys_rst <= last & ~service & ~do_stop & rst_en;
      aux_rst <= last & ~service & ~do_stop & aux_en;
    end
  end

  assign irq = pend & int_en;

  always_comb begin
    rdata = '0;
    if (!wdt_sel) begin
      case (addr)
        4'h0: rdata = {tmr_en, tmr_per, 30'(period)};
        4'h4: rdata[30] = pend;
        default: rdata = '0;
      endcase
    end else begin
      case (addr)
        4'h0: begin
          rdata[SRC_W-1:0] = src;
          rdata[12] = int_en;
          rdata[14] = rst_en;
          rdata[15] = aux_en;
        end
        4'h8: begin
          rdata[0] = running;
          rdata[8 +: CW] = exp_cnt;
        end
        default: rdata = '0;
      endcase
    end
  end

  assert_pend_from_expiry_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(tmr_en && count == '0));
  assert_enable_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tmr_en) |-> $past(tv_wr || (!tmr_per && count == '0)));
  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |=> !sys_rst);
  assert_reset_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |-> ($past(rst_en) && $past(running) && pend));
  assert_run_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    exp_cnt < CW'(EXPIRIES));
  assert_stop_needs_key_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running) |-> $past(unlocked && cmd_wr));
  assert_source_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (src != '0) |=> $stable(exp_cnt) || exp_cnt == '0);
endmodule

// File: tb/wdt_expiry_guard_test.sv
module wdt_expiry_guard_test;
  logic clk = 0, rst_n = 0, wr_en = 0, wdt_sel = 0;
  logic [3:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic irq, sys_rst, aux_rst;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wdt_expiry_guard uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdt_sel(wdt_sel),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .sys_rst(sys_rst), .aux_rst(aux_rst));

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input bit s, input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wdt_sel = s; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input bit s, input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); wdt_sel = s; addr = a; #1 d = rdata;
  endtask

  task automatic prep(input logic [31:0] cfg);
    wr(0, 4'h0, 0);
    wr(0, 4'h4, 32'h4000_0000);
    wr(1, 4'h0, cfg);
    wr(1, 4'h8, 1);
  endtask

  int first_irq, first_sys, first_aux, nsys, naux, nirq;
  task automatic run(input int n);
    first_irq = -1; first_sys = -1; first_aux = -1; nsys = 0; naux = 0; nirq = 0;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      if (irq) begin nirq++; if (first_irq < 0) first_irq = k; end
      if (sys_rst) begin nsys++; if (first_sys < 0) first_sys = k; end
      if (aux_rst) begin naux++; if (first_aux < 0) first_aux = k; end
    end
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10 reset state
    rd(0, 4'h0, d); check(d == 0, "R10 timer reg reset", d, 0);
    rd(1, 4'h0, d); check(d == 0, "R10 cfg reset", d, 0);
    rd(1, 4'h8, d); check(d == 0, "R10 cmd reset", d, 0);
    check(!irq && !sys_rst && !aux_rst, "R10 outputs reset", irq, 0);

    // R1 R6 sweep of periods
    for (int p = 0; p <= 5; p++) begin
      prep(32'h0000_D000);
      wr(0, 4'h0, 32'hC000_0000 | p);
      run(4 * (p + 1) + 1);
      check(first_irq == p + 1, "R1 first expiry cycle", first_irq, p + 1);
      check(first_sys == 4 * (p + 1), "R6 sys_rst cycle", first_sys, 4 * (p + 1));
      check(nsys == 1, "R6 sys_rst single pulse", nsys, 1);
      check(first_aux == 4 * (p + 1), "R6 aux_rst cycle", first_aux, 4 * (p + 1));
    end

    // R10 config readback
    wr(1, 4'h0, 32'h0000_D005);
    rd(1, 4'h0, d); check(d == 32'h0000_D005, "R10 cfg readback", d, 32'hD005);

    // R4 R5 clear pending, irq gating
    prep(32'h0000_0000);
    wr(0, 4'h0, 32'hC000_0002);
    run(4);
    wr(0, 4'h0, 0);
    rd(0, 4'h4, d); check(d[30] == 1, "R4 pending readable", d[30], 1);
    check(irq == 0, "R5 irq masked", irq, 0);
    wr(1, 4'h0, 32'h0000_1000);
    #1 check(irq == 1, "R5 irq with enable", irq, 1);
    wr(0, 4'h4, 32'h4000_0000);
    rd(0, 4'h4, d); check(d[30] == 0, "R4 pending cleared", d[30], 0);
    check(irq == 0, "R4 irq dropped", irq, 0);

    // R6 gating: aux only
    prep(32'h0000_8000);
    wr(0, 4'h0, 32'hC000_0002);
    run(13);
    check(nsys == 0, "R6 sys_rst gated off", nsys, 0);
    check(naux == 1 && first_aux == 12, "R6 aux_rst alone", first_aux, 12);
    check(nirq == 0, "R5 irq disabled", nirq, 0);

    // R2 one-shot
    prep(32'h0000_D000);
    wr(0, 4'h0, 32'h8000_0003);
    run(30);
    check(first_irq == 4, "R2 one-shot expiry", first_irq, 4);
    check(nsys == 0, "R2 one-shot no reset", nsys, 0);
    rd(0, 4'h0, d); check(d == 32'h0000_0003, "R2 enable cleared", d, 3);

    // R3 stop by writing zero
    prep(32'h0000_D000);
    wr(0, 4'h0, 32'hC000_0001);
    wr(0, 4'h0, 0);
    wr(0, 4'h4, 32'h4000_0000);
    run(20);
    check(nirq == 0 && nsys == 0, "R3 timer stopped", nirq, 0);
    rd(0, 4'h0, d); check(d == 0, "R3 timer reg zero", d, 0);

    // R7 service by clearing pending
    prep(32'h0000_D000);
    wr(0, 4'h0, 32'hC000_0007);
    nsys = 0; nirq = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (sys_rst) nsys++;
      if (irq) begin nirq++; wr_en = 1; wdt_sel = 0; addr = 4'h4; wdata = 32'h4000_0000; end
      else wr_en = 0;
    end
    wr_en = 0;
    check(nsys == 0, "R7 serviced no reset", nsys, 0);
    check(nirq >= 10, "R7 expiries kept occurring", nirq, 12);

    // R7 restart via start command
    prep(32'h0000_D000);
    wr(0, 4'h0, 32'hC000_0003);
    run(12);
    check(nsys == 0, "R7 three expiries no reset", nsys, 0);
    wr(1, 4'h8, 1);
    run(15);
    check(first_sys == 14, "R7 restart delays reset", first_sys, 14);

    // R9 source select
    prep(32'h0000_D001);
    wr(0, 4'h0, 32'hC000_0001);
    run(40);
    check(nsys == 0 && naux == 0, "R9 other source not counted", nsys, 0);

    // R8 keyed stop
    prep(32'h0000_0000);
    wr(1, 4'h8, 2);
    rd(1, 4'h8, d); check(d[0] == 1, "R8 stop without key ignored", d[0], 1);
    wr(1, 4'hC, 32'h0000_C45B); wr(1, 4'h8, 2);
    rd(1, 4'h8, d); check(d[0] == 1, "R8 wrong key ignored", d[0], 1);
    wr(1, 4'hC, 32'h0000_C45A); wr(1, 4'h0, 0); wr(1, 4'h8, 2);
    rd(1, 4'h8, d); check(d[0] == 1, "R8 key consumed by other write", d[0], 1);
    wr(1, 4'hC, 32'h0000_C45A); wr(1, 4'h8, 2);
    rd(1, 4'h8, d); check(d[0] == 0, "R8 keyed stop accepted", d[0], 0);
    wr(1, 4'h8, 1); wr(1, 4'h8, 2);
    rd(1, 4'h8, d); check(d[0] == 1, "R8 key used once", d[0], 1);
    wr(1, 4'h0, 32'h0000_4000);
    wr(0, 4'h0, 32'hC000_0001);
    run(9);
    check(first_sys == 8, "R8 running supervisor resets", first_sys, 8);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule